// File: doc/BRIEF.md
# Cascadable 3x3 Neighbourhood Line-Buffer Feeder

This block turns a raster-order pixel stream into a complete 3x3 neighbourhood on every pixel clock, so a spatial operator (convolution, rank filter, morphology) can sit directly behind it. It keeps the two preceding rows of the frame plus the part of the current row received so far. The row stores form a chain: a pixel leaves the store for the row above the current one and moves into the store for the row above that. An optional second image, the mask, goes through its own identical chain, so operators that take two images see both neighbourhoods together. The pixel width is a parameter: 8 for grayscale, 1 for binary.

Alongside the window, the block sends the input pixel, the mask pixel and the frame/row markers back out. They are delayed by exactly one row plus one pixel, so they stay aligned with the window centre. Identical units can therefore be chained, each one feeding the next. The row length comes from a run-time input that is sampled with the start-of-frame pixel. It may be any value from 3 up to a compile-time maximum.

A small controller sequences the frame fill through four states. IDLE waits for a start-of-frame pixel. FILL_TOP receives the first row. FILL_MID receives the second row. RUN covers every later row. The transitions are: any accepted pixel with `in_sof` goes to FILL_TOP; the last column of FILL_TOP goes to FILL_MID; the last column of FILL_MID goes to RUN; RUN stays in RUN until the next `in_sof`.

Top module: `line_feeder3x3`

## Requirements
- R1: A pixel is accepted when `in_valid` is high. Let the accepted pixel be at row r, column c. From the next clock on, `win_pix` holds rows r-2..r and columns c-2..c. Tap k = 3*row + col sits at bits [k*PIX_W +: PIX_W]. Row 0 is the oldest row and column 0 is the leftmost column.
- R2: `win_valid` is high in the cycle after a pixel with r >= 2 and c >= 1 is accepted. It is low in every other cycle.
- R3: When the accepted column is c = 1, the three left-column taps (k = 0, 3, 6) of both windows read zero.
- R4: `out_valid` and `out_pix` repeat the accepted input stream delayed by row_len+1 accepted pixels. Each output appears in the cycle after the pixel that completes that delay is accepted.
- R5: `out_sof` and `out_eol` are the `in_sof` and `in_eol` flags of the pixel shown on `out_pix`. `out_sof` is never high in two consecutive cycles.
- R6: `win_mask` and `out_mask` treat `in_mask` exactly as R1, R3 and R4 treat `in_pix`.
- R7: A cycle with `in_valid` low changes no window tap and drives `out_valid` and `win_valid` low in the next cycle.
- R8: Pixels that arrive before the first `in_sof` are ignored. A pixel with `in_sof` restarts the fill from row 0, column 0, at any point in a frame.
- R9: `row_len` is sampled only with the `in_sof` pixel. That value sets where every row of the frame wraps. Changes to `row_len` during a frame have no effect.
- R10: After reset, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_len | input | $clog2(MAX_COLS+1) | Pixels per row, sampled with `in_sof` |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row, carried through |
| in_pix | input | PIX_W | Image pixel |
| in_mask | input | PIX_W | Mask image pixel |
| win_valid | output | 1 | Window fully inside valid rows |
| win_pix | output | 9*PIX_W | 3x3 image window |
| win_mask | output | 9*PIX_W | 3x3 mask window |
| out_valid | output | 1 | Re-emitted stream valid |
| out_sof | output | 1 | Re-emitted frame start |
| out_eol | output | 1 | Re-emitted row end |
| out_pix | output | PIX_W | Re-emitted image pixel (window centre) |
| out_mask | output | PIX_W | Re-emitted mask pixel (window centre) |

## Verification
A row wrap and a frame restart can fall in the same cycle. The bench provokes this by cutting one frame short after a few pixels and starting the next frame, with a different row length, on the very next pixel. It then judges the outcome against a scoreboard model that has forgotten the aborted frame. In the same way, a stall gap can fall exactly where the pass-through stream is due to resume. The bench places gaps on fixed pixel counts and checks that no output appears during a gap and that the window resumes intact after it.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_FILL_TOP = 2'd1,
        S_FILL_MID = 2'd2,
        S_RUN      = 2'd3
    } fill_state_t;

    localparam int WIN_TAPS = 9;
    localparam int CENTRE_TAP = 4;
endpackage

// File: rtl/lbf_ctrl.sv
module lbf_ctrl
    import lbf_pkg::*;
#(
    parameter int MAX_COLS = 32,
    parameter int AW       = 5,
    parameter int COL_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [COL_W-1:0] row_len,
    output logic             shift,
    output logic [AW-1:0]    addr,
    output logic             win_valid,
    output logic             out_valid,
    output logic             pad_left
);
    fill_state_t      state_q, state_d;
    logic [AW-1:0]    col_q, col_d;
    logic [COL_W-1:0] len_q, len_d;
    logic [AW-1:0]    cur_col;
    logic [COL_W-1:0] eff_len;
    logic [1:0]       row_code;
    logic             last_col;
    logic             accept;

    assign accept  = in_valid && (in_sof || state_q != S_IDLE);
    assign cur_col = in_sof ? '0 : col_q;
    assign eff_len = in_sof ? row_len : len_q;
    assign last_col = (COL_W'(cur_col) == eff_len - COL_W'(1));
    assign shift   = accept;
    assign addr    = cur_col;

    always_comb begin
        if (in_sof)                  row_code = 2'd0;
        else if (state_q == S_RUN)   row_code = 2'd2;
        else if (state_q == S_FILL_MID) row_code = 2'd1;
        else                         row_code = 2'd0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        len_d   = len_q;
        if (accept) begin
            col_d = last_col ? '0 : cur_col + 1'b1;
            if (in_sof) begin
                len_d   = row_len;
                state_d = last_col ? S_FILL_MID : S_FILL_TOP;
            end else begin
                unique case (state_q)
                    S_IDLE:     state_d = S_IDLE;
                    S_FILL_TOP: state_d = last_col ? S_FILL_MID : S_FILL_TOP;
                    S_FILL_MID: state_d = last_col ? S_RUN : S_FILL_MID;
                    S_RUN:      state_d = S_RUN;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            col_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            len_q   <= len_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            out_valid <= 1'b0;
            pad_left  <= 1'b0;
        end else begin
            win_valid <= accept && (row_code == 2'd2) && (cur_col != '0);
            out_valid <= accept && ((row_code == 2'd2) ||
                                    (row_code == 2'd1 && cur_col != '0));
            if (accept) pad_left <= (cur_col == AW'(1));
        end
    end

    assert_col_in_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (COL_W'(col_q) < len_q));

    assert_win_within_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> out_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !in_sof) |=> !out_valid);
endmodule

// File: rtl/lbf_plane.sv
module lbf_plane #(
    parameter int W        = 8,
    parameter int MAX_COLS = 32,
    parameter int AW       = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    din,
    output logic [9*W-1:0]  win
);
    logic [W-1:0] row_near [MAX_COLS];
    logic [W-1:0] row_far  [MAX_COLS];
    logic [W-1:0] near_rd, far_rd;
    logic [W-1:0] tap_q [3][3];

    assign near_rd = row_near[addr];
    assign far_rd  = row_far[addr];

    // chained row stores: the previous row spills into the one above it
    always_ff @(posedge clk) begin
        if (shift) begin
            row_near[addr] <= din;
            row_far[addr]  <= near_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    tap_q[r][c] <= '0;
        end else if (shift) begin
            for (int r = 0; r < 3; r++) begin
                tap_q[r][0] <= tap_q[r][1];
                tap_q[r][1] <= tap_q[r][2];
            end
            tap_q[0][2] <= far_rd;
            tap_q[1][2] <= near_rd;
            tap_q[2][2] <= din;
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign win[(r*3+c)*W +: W] = tap_q[r][c];
        end
    end

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(win));
endmodule

// File: rtl/lbf_flag_delay.sv
module lbf_flag_delay #(
    parameter int FW       = 2,
    parameter int MAX_COLS = 32,
    parameter int AW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic [AW-1:0] addr,
    input  logic [FW-1:0] din,
    output logic [FW-1:0] centre
);
    logic [FW-1:0] row_mem [MAX_COLS];
    logic [FW-1:0] rd;
    logic [FW-1:0] stage_q;

    assign rd = row_mem[addr];

    always_ff @(posedge clk) begin
        if (shift) row_mem[addr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            centre  <= '0;
        end else if (shift) begin
            stage_q <= rd;
            centre  <= stage_q;
        end
    end
endmodule

// File: rtl/line_feeder3x3.sv
module line_feeder3x3
    import lbf_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int MAX_COLS = 32,
    parameter int MASK_EN  = 1,
    localparam int AW      = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1,
    localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COL_W-1:0]          row_len,
    input  logic                      in_valid,
    input  logic                      in_sof,
    input  logic                      in_eol,
    input  logic [PIX_W-1:0]          in_pix,
    input  logic [PIX_W-1:0]          in_mask,
    output logic                      win_valid,
    output logic [WIN_TAPS*PIX_W-1:0] win_pix,
    output logic [WIN_TAPS*PIX_W-1:0] win_mask,
    output logic                      out_valid,
    output logic                      out_sof,
    output logic                      out_eol,
    output logic [PIX_W-1:0]          out_pix,
    output logic [PIX_W-1:0]          out_mask
);
    logic          shift;
    logic [AW-1:0] addr;
    logic          pad_left;
    logic [WIN_TAPS*PIX_W-1:0] img_win;
    logic [WIN_TAPS*PIX_W-1:0] msk_win;
    logic [1:0]    flags;

    lbf_ctrl #(.MAX_COLS(MAX_COLS), .AW(AW), .COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .row_len(row_len), .shift(shift), .addr(addr),
        .win_valid(win_valid), .out_valid(out_valid), .pad_left(pad_left)
    );

    lbf_plane #(.W(PIX_W), .MAX_COLS(MAX_COLS), .AW(AW)) u_img (
        .clk(clk), .rst_n(rst_n), .shift(shift), .addr(addr),
        .din(in_pix), .win(img_win)
    );

    lbf_flag_delay #(.FW(2), .MAX_COLS(MAX_COLS), .AW(AW)) u_flags (
        .clk(clk), .rst_n(rst_n), .shift(shift), .addr(addr),
        .din({in_eol, in_sof}), .centre(flags)
    );

    if (MASK_EN != 0) begin : g_mask
        lbf_plane #(.W(PIX_W), .MAX_COLS(MAX_COLS), .AW(AW)) u_msk (
            .clk(clk), .rst_n(rst_n), .shift(shift), .addr(addr),
            .din(in_mask), .win(msk_win)
        );
    end else begin : g_nomask
        assign msk_win = '0;
    end

    for (genvar k = 0; k < WIN_TAPS; k++) begin : g_tap
        assign win_pix[k*PIX_W +: PIX_W]  = (pad_left && (k % 3 == 0)) ? '0
                                            : img_win[k*PIX_W +: PIX_W];
        assign win_mask[k*PIX_W +: PIX_W] = (pad_left && (k % 3 == 0)) ? '0
                                            : msk_win[k*PIX_W +: PIX_W];
    end

    assign out_pix  = img_win[CENTRE_TAP*PIX_W +: PIX_W];
    assign out_mask = msk_win[CENTRE_TAP*PIX_W +: PIX_W];
    assign out_sof  = out_valid & flags[0];
    assign out_eol  = out_valid & flags[1];

    assert_sof_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof);
endmodule

// File: tb/line_feeder3x3_test.sv
module line_feeder3x3_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int MC = 32;
    localparam int CW = $clog2(MC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] row_len = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [PW-1:0] in_pix = '0, in_mask = '0;
    logic win_valid, out_valid, out_sof, out_eol;
    logic [9*PW-1:0] win_pix, win_mask;
    logic [PW-1:0] out_pix, out_mask;

    line_feeder3x3 #(.PIX_W(PW), .MAX_COLS(MC), .MASK_EN(1)) uut (
        .clk(clk), .rst_n(rst_n), .row_len(row_len), .in_valid(in_valid),
        .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix), .in_mask(in_mask),
        .win_valid(win_valid), .win_pix(win_pix), .win_mask(win_mask),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
        .out_pix(out_pix), .out_mask(out_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int due;
        logic [PW-1:0] pix, msk;
        logic sof, eol, wv, pad;
        logic [9*PW-1:0] win, mwin;
    } exp_t;

    exp_t q[$];
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit mon_on = 0;
    logic [PW-1:0] img [0:7][0:31];
    logic [PW-1:0] mimg [0:7][0:31];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [9*PW-1:0] act, input logic [9*PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items when they fall due
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (q.size() > 0 && q[0].due <= cyc) begin
                e = q.pop_front();
                chk("R4 out_valid", 72'(out_valid), 72'(1));
                chk("R4 out_pix", 72'(out_pix), 72'(e.pix));
                chk("R6 out_mask", 72'(out_mask), 72'(e.msk));
                chk("R5 out_sof", 72'(out_sof), 72'(e.sof));
                chk("R5 out_eol", 72'(out_eol), 72'(e.eol));
                chk("R2 win_valid", 72'(win_valid), 72'(e.wv));
                if (e.wv) begin
                    chk(e.pad ? "R3 padded win_pix" : "R1 win_pix", win_pix, e.win);
                    chk(e.pad ? "R3 padded win_mask" : "R6 win_mask", win_mask, e.mwin);
                end
            end else begin
                chk("R7 or R8 idle out_valid", 72'(out_valid), 72'(0));
                chk("R2 idle win_valid", 72'(win_valid), 72'(0));
            end
        end
    end

    task automatic drive_frame(input int rows, input int L, input int nmax,
                               input int gap, input int base);
        int k = 0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < L; c++) begin
                exp_t e;
                if (k >= nmax) return;
                @(negedge clk);
                if (gap > 0 && k > 0 && (k % gap) == 0) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                img[r][c]  = PW'(base + r*16 + c*3);
                mimg[r][c] = img[r][c] ^ 8'hA5;
                in_valid = 1'b1;
                in_sof   = (k == 0);
                in_eol   = (c == L-1);
                in_pix   = img[r][c];
                in_mask  = mimg[r][c];
                row_len  = (k == 0) ? CW'(L) : CW'(4); // R9: later values ignored
                if (k >= L + 1) begin
                    int idx = k - L - 1;
                    int cr = idx / L;
                    int cc = idx % L;
                    e.due = cyc + 1;
                    e.pix = img[cr][cc];
                    e.msk = mimg[cr][cc];
                    e.sof = (idx == 0);
                    e.eol = (cc == L-1);
                    e.wv  = (r >= 2) && (c >= 1);
                    e.pad = (c == 1);
                    e.win = '0;
                    e.mwin = '0;
                    if (e.wv) begin
                        for (int i = 0; i < 3; i++) begin
                            for (int j = 0; j < 3; j++) begin
                                int rr = r - 2 + i;
                                int cx = c - 2 + j;
                                if (cx >= 0) begin
                                    e.win[(i*3+j)*PW +: PW]  = img[rr][cx];
                                    e.mwin[(i*3+j)*PW +: PW] = mimg[rr][cx];
                                end
                            end
                        end
                    end
                    q.push_back(e);
                end
                k++;
            end
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R4 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset win_valid", 72'(win_valid), 72'(0));
        chk("R10 reset out_valid", 72'(out_valid), 72'(0));
        chk("R10 reset flags", 72'({out_sof, out_eol}), 72'(0));
        chk("R10 reset out_pix", 72'({out_pix, out_mask}), 72'(0));
        chk("R10 reset win_pix", win_pix, '0);
        chk("R10 reset win_mask", win_mask, '0);
        rst_n = 1'b1;
        mon_on = 1;
        // R8: pixels before any frame start are dropped
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_pix = PW'(200 + i); in_mask = PW'(i);
        end
        @(negedge clk) in_valid = 1'b0;
        // R1, R3: plain frame
        drive_frame(5, 5, 1000, 0, 1);
        // R7, R9: stalls and a longer row; row_len port wiggles mid-frame
        drive_frame(4, 7, 1000, 3, 90);
        // R8: frame cut short, next frame starts immediately with new length
        drive_frame(5, 5, 8, 0, 150);
        drive_frame(4, 6, 1000, 2, 7);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 scoreboard drained", 72'(q.size()), 72'(0));
        summary();
        $finish;
    end
endmodule